// File: doc/BRIEF.md
# Double-Buffered Dual-Alignment PWM Generator

This block is one PWM generator channel clocked from the bus clock. A 15-bit counter, advanced by a power-of-two prescaler (divide by 1, 2, 4 or 8), either ramps up and wraps (edge-aligned) or ramps up and back down (center-aligned). The counter value is compared against a duty value to produce a single raw PWM level. Each period ends in a reload boundary, flagged by a pulse one bus clock wide.

Software programs the alignment mode, prescaler code, modulus and duty through a small synchronous write port. These writes land in shadow registers. A commit strobe arms a pending flag. At the next reload boundary all shadow settings are copied to the working set together, the counter restarts from zero and the prescaler phase restarts. The pending flag then clears itself. Without a commit, the generator keeps running on its old settings however often the shadows are rewritten.

Register map (write port, `wr_data` bits): address 0 is control, with bit 0 = alignment (1 = center, 0 = edge) and bits 2:1 = prescaler code. Address 1 is the modulus in bits 14:0. Address 2 is the duty in bits 14:0. Address 3 is ignored.

Top module: `pwm_dual_align_gen`

## Requirements
- R1: After reset the counter output is 0, the PWM output is low and no reload pulse is raised. The working set is edge-aligned, prescaler code 0, modulus 0 and duty 0, and nothing is pending. With `en` high in this state, every bus clock is a reload boundary.
- R2: Prescaler code c (control bits 2:1) makes the counter advance once every 2^c bus clocks. Codes 0, 1, 2 and 3 give divide by 1, 2, 4 and 8. Every period and high time in PWM clocks is multiplied by 2^c in bus clocks.
- R3: In edge-aligned mode (control bit 0 = 0) the counter steps 0, 1, …, M−1 and wraps, giving a period of M PWM clocks. The output is high while the counter is below the duty D, so the high time is D PWM clocks.
- R4: In center-aligned mode (control bit 0 = 1) the counter steps up from 0 to M and then down to 1, giving a period of 2·M PWM clocks. The output is high for 2·D PWM clocks, centered on the turn-around. For example, M = 4 and D = 2 give a period of 8 and a high time of 4.
- R5: A duty of 0 keeps the output low for the whole period. A duty at or above the modulus (modulus nonzero) keeps it high for the whole period.
- R6: Writes to the control, modulus and duty addresses change only the shadow registers. The running period and pulse width are unchanged until a commit.
- R7: A `commit_req` pulse sets a pending flag. At the first reload boundary after the request cycle, all shadow fields are copied to the working set at once, and the counter and prescaler restart from zero. The pending flag then clears, so later boundaries copy nothing until the next request.
- R8: `reload_pulse` is high for exactly one bus clock, in the last bus clock of each period: the clock in which the counter steps back to 0.
- R9: While `en` is low, the counter and prescaler hold their state and no reload pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for prescaler and counter |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 2 | Shadow register address |
| wr_data | input | 16 | Shadow register write data |
| commit_req | input | 1 | Arms the shadow-to-working copy |
| pwm_out | output | 1 | Raw PWM level |
| reload_pulse | output | 1 | One-bus-clock pulse at each reload boundary |
| cnt_o | output | 15 | Current counter value |

## Verification
The assertions assume that the write port, `commit_req` and `en` are driven synchronously and hold known values from reset onward. They also assume that the working modulus changes only through a commit, which puts the counter back at zero in the same step. The bounds on the counter value are valid under these conditions. The stimulus enables the generator only after reset is released. It changes inputs only at the falling edge and raises `commit_req` for single cycles, so each armed commit meets a well-defined reload boundary.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int CNT_W = 15;
  localparam int PS_W  = 2;
  localparam int DAT_W = 16;
  localparam int ADR_W = 2;
  // prescaler phase counter needs one bit per doubling at the largest code
  localparam int PSC_W = (1 << PS_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic            center;
    logic [PS_W-1:0] ps;
    cnt_t            modv;
    cnt_t            duty;
  } pwm_cfg_t;

  localparam logic [ADR_W-1:0] ADR_CTRL = ADR_W'(0);
  localparam logic [ADR_W-1:0] ADR_MOD  = ADR_W'(1);
  localparam logic [ADR_W-1:0] ADR_DUTY = ADR_W'(2);

  // low bits that must all be ones for a prescaler tick
  function automatic logic [PSC_W-1:0] ps_mask(logic [PS_W-1:0] code);
    logic [PSC_W-1:0] m;
    m = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i < int'(code)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // true when the next PWM tick closes the period
  function automatic logic period_end(pwm_cfg_t c, logic down, cnt_t cnt);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + (CNT_W+1)'(1);
    if (c.center)
      return ((c.modv <= cnt_t'(1)) && (cnt >= c.modv)) || (down && (cnt <= cnt_t'(1)));
    return nxt >= {1'b0, c.modv};
  endfunction

  // output level for the current counter state
  function automatic logic pwm_level(pwm_cfg_t c, logic down, cnt_t cnt);
    cnt_t th;
    if (!c.center) return cnt < c.duty;
    if (c.duty == '0) return 1'b0;
    th = (c.duty >= c.modv) ? '0 : (c.modv - c.duty);
    return down ? (cnt > th) : (cnt >= th);
  endfunction
endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
  import pwm_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             commit_req,
  input  logic             reload_evt,
  output pwm_cfg_t         act,
  output logic             pend,
  output logic             commit_now
);
  pwm_cfg_t shd;

  assign commit_now = reload_evt & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          shd.center <= wr_data[0];
          shd.ps     <= wr_data[PS_W:1];
        end
        ADR_MOD:  shd.modv <= wr_data[CNT_W-1:0];
        ADR_DUTY: shd.duty <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= '0;
      pend <= 1'b0;
    end else begin
      if (commit_now) act <= shd;
      if (commit_req)      pend <= 1'b1;
      else if (commit_now) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_clk_div.sv
module pwm_clk_div
  import pwm_gen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] code,
  input  logic            restart,
  output logic            tick
);
  logic [PSC_W-1:0] phase;
  logic [PSC_W-1:0] mask;

  assign mask = ps_mask(code);
  assign tick = en && ((phase & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (en)      phase <= phase + PSC_W'(1);
  end
endmodule

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt
  import pwm_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     restart,
  input  pwm_cfg_t cfg,
  output cnt_t     cnt,
  output logic     down,
  output logic     at_end
);
  assign at_end = period_end(cfg, down, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      if (at_end || restart) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (cfg.center && !down && (cnt >= cfg.modv)) begin
        down <= 1'b1;
        cnt  <= cnt - cnt_t'(1);
      end else if (down) begin
        cnt  <= cnt - cnt_t'(1);
      end else begin
        cnt  <= cnt + cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_dual_align_gen.sv
module pwm_dual_align_gen
  import pwm_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             commit_req,
  output logic             pwm_out,
  output logic             reload_pulse,
  output logic [CNT_W-1:0] cnt_o
);
  pwm_cfg_t act_cfg;
  logic     pend;
  logic     commit_now;
  logic     tick;
  logic     at_end;
  logic     cnt_down;
  cnt_t     cnt;
  logic     reload_evt;

  assign reload_evt = tick & at_end;

  pwm_cfg_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .commit_req (commit_req),
    .reload_evt (reload_evt),
    .act        (act_cfg),
    .pend       (pend),
    .commit_now (commit_now)
  );

  pwm_clk_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .code    (act_cfg.ps),
    .restart (commit_now),
    .tick    (tick)
  );

  pwm_updown_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (commit_now),
    .cfg     (act_cfg),
    .cnt     (cnt),
    .down    (cnt_down),
    .at_end  (at_end)
  );

  assign pwm_out      = pwm_level(act_cfg, cnt_down, cnt);
  assign reload_pulse = reload_evt;
  assign cnt_o        = cnt;
endmodule

// File: rtl/pwm_dual_align_gen_chk.sv
module pwm_dual_align_gen_chk
  import pwm_gen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             commit_req,
  input logic             tick,
  input logic             pend,
  input logic             commit_now,
  input pwm_cfg_t         act,
  input logic             cnt_down,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pwm_out,
  input logic             reload_pulse
);
  // R9: nothing moves and no boundary is flagged while disabled
  a_r9_no_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !reload_pulse);
  a_r9_hold_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_o));

  // R2: a nonzero code never yields ticks on consecutive bus clocks
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit_now && act.ps != '0) |=> !tick);

  // R3: edge-aligned counter stays below the modulus
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!act.center && act.modv != '0) |-> (cnt_o < act.modv));

  // R4: center-aligned counter peaks at the modulus and never descends at zero
  a_r4_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act.center |-> (cnt_o <= act.modv));
  a_r4_down_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (act.center && cnt_down) |-> (cnt_o != '0));

  // R5: duty extremes
  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act.duty == '0) |-> !pwm_out);
  a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (act.modv != '0 && act.duty >= act.modv) |-> pwm_out);

  // R6/R7: working set changes only on a commit, and pending clears after it
  a_r6_act_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_now |=> $stable(act));
  a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && commit_now && !commit_req) |=> !pend);
  a_r7_commit_restart: assert property (@(posedge clk) disable iff (!rst_n)
    commit_now |=> (cnt_o == '0));
endmodule

bind pwm_dual_align_gen pwm_dual_align_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .commit_req   (commit_req),
  .tick         (tick),
  .pend         (pend),
  .commit_now   (commit_now),
  .act          (act_cfg),
  .cnt_down     (cnt_down),
  .cnt_o        (cnt_o),
  .pwm_out      (pwm_out),
  .reload_pulse (reload_pulse)
);

// File: tb/pwm_dual_align_gen_tb.sv
`timescale 1ns/1ps
module pwm_dual_align_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        commit_req = 1'b0;
  logic        pwm_out;
  logic        reload_pulse;
  logic [14:0] cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_dual_align_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .commit_req   (commit_req),
    .pwm_out      (pwm_out),
    .reload_pulse (reload_pulse),
    .cnt_o        (cnt_o)
  );

  // center, prescaler code, modulus, duty, period (bus clocks), high time (bus clocks)
  localparam int NV = 10;
  localparam int TV [NV][6] = '{
    '{0, 0, 4, 2,  4,  2},
    '{1, 0, 4, 2,  8,  4},
    '{0, 1, 5, 3, 10,  6},
    '{1, 2, 3, 1, 24,  8},
    '{0, 0, 6, 0,  6,  0},
    '{0, 0, 6, 9,  6,  6},
    '{1, 3, 2, 2, 32, 32},
    '{1, 0, 5, 0, 10,  0},
    '{0, 3, 3, 1, 24,  8},
    '{1, 0, 7, 3, 14,  6}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(int addr, int data);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit();
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
  endtask

  // sync to the next reload boundary, then count one full period
  task automatic measure(output int per, output int hi, output int pk);
    per = 0; hi = 0; pk = 0;
    while (reload_pulse !== 1'b1) @(negedge clk);
    do begin
      @(negedge clk);
      per++;
      if (pwm_out) hi++;
      if (int'(cnt_o) > pk) pk = int'(cnt_o);
    end while (reload_pulse !== 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int per, hi, pk, c0, bad;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cnt in reset", int'(cnt_o), 0);
    chk("R1 out in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", int'(reload_pulse), 0);
    chk("R1 cnt after reset", int'(cnt_o), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R1 default boundary every clock", int'(reload_pulse), 1);
    chk("R1 default output low", int'(pwm_out), 0);

    // R2 R3 R4 R5 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      write_reg(0, TV[i][0] | (TV[i][1] << 1));
      write_reg(1, TV[i][2]);
      write_reg(2, TV[i][3]);
      commit();
      measure(per, hi, pk);
      chk($sformatf("R2/R3/R4 period vec%0d", i), per, TV[i][4]);
      chk($sformatf("R3/R4/R5 high time vec%0d", i), hi, TV[i][5]);
      chk($sformatf("R3/R4 counter peak vec%0d", i), pk,
          (TV[i][0] != 0) ? TV[i][2] : TV[i][2] - 1);
      @(negedge clk);
      chk($sformatf("R8 pulse one clock vec%0d", i), int'(reload_pulse), 0);
    end

    // R6: shadow write without commit keeps the running waveform
    write_reg(0, 0);
    write_reg(1, 3);
    write_reg(2, 1);
    measure(per, hi, pk);
    chk("R6 period unchanged", per, 14);
    chk("R6 high unchanged", hi, 6);

    // R7: commit applies all fields, then pending clears
    commit();
    measure(per, hi, pk);
    chk("R7 committed period", per, 3);
    chk("R7 committed high", hi, 1);
    write_reg(1, 9);
    measure(per, hi, pk);
    chk("R7 no second copy p1", per, 3);
    measure(per, hi, pk);
    chk("R7 no second copy p2", per, 3);

    // R9: disabled generator freezes
    en = 1'b0;
    c0 = int'(cnt_o);
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (int'(cnt_o) != c0 || reload_pulse) bad++;
    end
    chk("R9 frozen while disabled", bad, 0);
    en = 1'b1;
    measure(per, hi, pk);
    chk("R9 resumes after enable", per, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule